// File: doc/BRIEF.md
# Newton-Raphson Square Root Unit

This block computes an approximate square root of an unsigned integer argument of 2P bits and returns a P-bit unsigned integer result. A one-cycle start pulse, accepted only while the unit is idle, captures the argument. The argument is then scaled by an even left shift so that, read as a fraction, it falls in [0.25, 1).

A small computed table, addressed by the leading T bits of the scaled value, supplies a first estimate of the reciprocal square root. A fixed number of Newton-Raphson steps refine that estimate. Each step squares the estimate, multiplies the square by the scaled argument, subtracts the product from three, multiplies the difference by the estimate and halves the outcome. A single multiplier is shared across all of these operations and is reused once more to form argument times reciprocal root. The result is rounded to nearest and shifted right by half the normalising shift. A one-cycle done pulse marks the new result, which stays on the output until the next completion.

Top module: `nr_sqrt_unit`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is 0 and `result_o` is 0 until the first operation completes.
- R2: A start seen in the idle state yields a `done_o` pulse exactly one cycle wide, high during the cycle that starts 3·K+1 rising edges after the capturing edge. K = ceil(log2(ceil(P/T))) + 1, which gives 10 edges with P=16 and T=4.
- R3: For every nonzero argument, `result_o` differs from the real square root of `arg_i`, both read as unsigned integers, by at most 2.
- R4: An argument of zero gives a result of exactly zero.
- R5: An argument equal to 4^j (j = 0 .. P-1) gives exactly 2^j.
- R6: A start raised while an operation is running has no effect. The running operation completes on its original schedule with its own result, and no extra done pulse follows.
- R7: Outside the done cycle, `result_o` holds its value whatever `arg_i` and `start_i` do.
- R8: An all-ones argument gives the largest P-bit value, 2^P-1. The rounded result saturates rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation when idle |
| arg_i | input | 2P | Unsigned argument, sampled with start |
| result_o | output | P | Unsigned square root, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on `arg_i` being consulted only on the edge that accepts a start, so the normalised operand held during a run must carry a nonzero leading pair whenever the argument is nonzero. They do not constrain `start_i` at all: start may be high in any cycle, including mid-run. The stimulus therefore drives start pulses at arbitrary points, including one in the middle of a run with a different argument. It changes `arg_i` freely while no start is present, and it drives all inputs on the falling edge so that every capture is unambiguous.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SQ,
    S_MX,
    S_UPD,
    S_FIN
  } nrs_state_e;
endpackage

// File: rtl/nrs_normalize.sv
// Even left shift of the argument so its leading nonzero bit pair is on top.
module nrs_normalize #(
  parameter int AW = 32,
  parameter int OW = 20,
  localparam int HW = $clog2(AW / 2)
) (
  input  logic [AW-1:0] arg_i,
  output logic [OW-1:0] mant_o,
  output logic [HW-1:0] half_shift_o,
  output logic          zero_o
);
  logic [AW-1:0] shifted;
  logic          found;

  always_comb begin
    found        = 1'b0;
    half_shift_o = '0;
    for (int j = AW / 2 - 1; j >= 0; j--) begin
      if (!found && (arg_i[2*j +: 2] != 2'b00)) begin
        found        = 1'b1;
        half_shift_o = HW'(AW / 2 - 1 - j);
      end
    end
    zero_o  = ~|arg_i;
    shifted = arg_i << {half_shift_o, 1'b0};
    mant_o  = OW'(shifted >> (AW - OW));
  end
endmodule

// File: rtl/nrs_seed_rom.sv
// Reciprocal square root first guess, contents computed at elaboration.
module nrs_seed_rom #(
  parameter int T = 4,
  parameter int W = 22,
  parameter int F = 20
) (
  input  logic [T-1:0] idx_i,
  output logic [W-1:0] seed_o
);
  // Returns y with T fraction bits closest to 1/sqrt of the interval midpoint.
  function automatic longint seed_val(input longint i);
    longint best, berr, tgt, e;
    tgt  = longint'(1) << (3 * T + 1);
    best = longint'(1) << (T + 1);
    berr = -1;
    if (i < (longint'(1) << (T - 2))) return best;
    for (longint y = longint'(1) << T; y <= (longint'(1) << (T + 1)); y++) begin
      e = y * y * (2 * i + 1) - tgt;
      if (e < 0) e = -e;
      if (berr < 0 || e < berr) begin
        berr = e;
        best = y;
      end
    end
    return best;
  endfunction

  logic [W-1:0] rom [2**T];

  for (genvar g = 0; g < 2**T; g++) begin : g_rom
    localparam longint SV = seed_val(g);
    assign rom[g] = W'(SV) << (F - T);
  end

  assign seed_o = rom[idx_i];
endmodule

// File: rtl/nrs_mul.sv
// Shared fixed-point multiplier, F fraction bits, optional halving, saturating.
module nrs_mul #(
  parameter int W = 22,
  parameter int F = 20
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         halve_i,
  output logic [W-1:0] p_o
);
  logic [2*W-1:0] full;
  logic [2*W-1:0] sh;

  always_comb begin
    full = (2*W)'(a_i) * (2*W)'(b_i);
    sh   = halve_i ? (full >> (F + 1)) : (full >> F);
    p_o  = (|sh[2*W-1:W]) ? '1 : sh[W-1:0];
  end
endmodule

// File: rtl/nr_sqrt_unit.sv
module nr_sqrt_unit
  import nrs_pkg::*;
#(
  parameter int P = 16,
  parameter int T = 4,
  parameter int G = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [2*P-1:0] arg_i,
  output logic [P-1:0]   result_o,
  output logic           done_o
);
  localparam int AW    = 2 * P;
  localparam int F     = P + G;
  localparam int W     = F + 2;
  localparam int HW    = $clog2(P);
  localparam int ITERS = $clog2((P + T - 1) / T) + 1;
  localparam int IW    = $clog2(ITERS + 1);
  localparam logic [W-1:0] THREE = W'(3) << F;

  // reset release synchroniser
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [F-1:0]  mant_n;
  logic [HW-1:0] hs_n;
  logic          zero_n;
  logic [W-1:0]  seed_n;

  nrs_normalize #(.AW(AW), .OW(F)) u_norm (
    .arg_i(arg_i), .mant_o(mant_n), .half_shift_o(hs_n), .zero_o(zero_n)
  );

  nrs_seed_rom #(.T(T), .W(W), .F(F)) u_seed (
    .idx_i(mant_n[F-1 -: T]), .seed_o(seed_n)
  );

  nrs_state_e    state_q, state_d;
  logic [IW-1:0] iter_q, iter_d;
  logic [W-1:0]  m_q, m_d, y_q, y_d, t_q, t_d;
  logic [HW-1:0] hs_q, hs_d;
  logic          zero_q, zero_d;
  logic [P-1:0]  result_d;
  logic          done_d;

  logic [W-1:0]  mul_a, mul_b, prod, diff;
  logic          mul_halve;
  logic [W-1:0]  shifted;
  logic [W:0]    rnd;
  logic [P-1:0]  res_n;

  nrs_mul #(.W(W), .F(F)) u_mul (
    .a_i(mul_a), .b_i(mul_b), .halve_i(mul_halve), .p_o(prod)
  );

  // operand selection for the shared multiplier
  always_comb begin
    diff      = (t_q > THREE) ? '0 : (THREE - t_q);
    mul_a     = y_q;
    mul_b     = y_q;
    mul_halve = 1'b0;
    unique case (state_q)
      S_MX:    begin mul_a = t_q;  mul_b = m_q; end
      S_UPD:   begin mul_a = diff; mul_b = y_q; mul_halve = 1'b1; end
      S_FIN:   begin mul_a = y_q;  mul_b = m_q; end
      default: begin mul_a = y_q;  mul_b = y_q; end
    endcase
  end

  // round to nearest and undo the normalising shift
  always_comb begin
    shifted = prod >> (int'(hs_q) + G - 1);
    rnd     = ({1'b0, shifted} + (W+1)'(1)) >> 1;
    res_n   = (|rnd[W:P]) ? '1 : rnd[P-1:0];
  end

  always_comb begin
    state_d  = state_q;
    iter_d   = iter_q;
    m_d      = m_q;
    y_d      = y_q;
    t_d      = t_q;
    hs_d     = hs_q;
    zero_d   = zero_q;
    result_d = result_o;
    done_d   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        m_d     = W'(mant_n);
        y_d     = seed_n;
        hs_d    = hs_n;
        zero_d  = zero_n;
        iter_d  = '0;
        state_d = S_SQ;
      end
      S_SQ: begin
        t_d     = prod;
        state_d = S_MX;
      end
      S_MX: begin
        t_d     = prod;
        state_d = S_UPD;
      end
      S_UPD: begin
        y_d     = prod;
        iter_d  = iter_q + IW'(1);
        state_d = (iter_q == IW'(ITERS - 1)) ? S_FIN : S_SQ;
      end
      S_FIN: begin
        result_d = zero_q ? '0 : res_n;
        done_d   = 1'b1;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= S_IDLE;
      iter_q   <= '0;
      m_q      <= '0;
      y_q      <= '0;
      t_q      <= '0;
      hs_q     <= '0;
      zero_q   <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      iter_q   <= iter_d;
      m_q      <= m_d;
      y_q      <= y_d;
      t_q      <= t_d;
      hs_q     <= hs_d;
      zero_q   <= zero_d;
      result_o <= result_d;
      done_o   <= done_d;
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);

  a_r2_done_after_fin: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> $past(state_q) == S_FIN);

  a_r3_norm_range: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != S_IDLE && !zero_q) |-> (m_q[F-1:F-2] != 2'b00));

  a_r4_zero_result: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && zero_q) |-> (result_o == '0));

  a_r6_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != S_IDLE) |=> ($stable(m_q) && $stable(hs_q) && $stable(zero_q)));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/tb_nr_sqrt_unit.sv
module tb_nr_sqrt_unit;
  localparam int P   = 16;
  localparam int T   = 4;
  localparam int AW  = 2 * P;
  localparam int K   = $clog2((P + T - 1) / T) + 1;
  localparam int LAT = 3 * K + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] arg_i;
  logic [P-1:0]  result_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nr_sqrt_unit #(.P(P), .T(T)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .arg_i(arg_i), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one operation; checks R2 latency and pulse width
  task automatic run_op(input logic [AW-1:0] x, output logic [P-1:0] res);
    int lat;
    @(negedge clk); arg_i = x; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk); lat++;
    end
    res = result_o;
    chk("R2 latency", lat == LAT, lat, LAT);
    @(negedge clk);
    chk("R2 pulse width", done_o == 1'b0, done_o, 0);
  endtask

  task automatic acc_check(input logic [AW-1:0] x);
    logic [P-1:0] r;
    real s, d;
    run_op(x, r);
    s = $sqrt(real'(x));
    d = real'(r) - s;
    if (d < 0.0) d = -d;
    chk("R3 accuracy", d <= 2.0, r, longint'(s));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; arg_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset done", done_o == 1'b0, done_o, 0);
    chk("R1 reset result", result_o == '0, result_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release done", done_o == 1'b0, done_o, 0);
    chk("R1 after release result", result_o == '0, result_o, 0);
  endtask

  task automatic t_small();
    for (int x = 1; x < 40; x++) acc_check(AW'(x));
  endtask

  task automatic t_powers_of_four();
    logic [P-1:0] r;
    for (int j = 0; j < P; j++) begin
      run_op(AW'(1) << (2 * j), r);
      chk("R5 power of four", r == (P'(1) << j), r, longint'(1) << j);
    end
  endtask

  task automatic t_zero();
    logic [P-1:0] r;
    run_op(AW'(12345), r);
    run_op('0, r);
    chk("R4 zero argument", r == '0, r, 0);
  endtask

  task automatic t_max();
    logic [P-1:0] r;
    run_op('1, r);
    chk("R8 saturated max", r == '1, r, (longint'(1) << P) - 1);
    acc_check(AW'(32'hFFFE_0001));
    acc_check(AW'(32'h3FFF_FFFF));
  endtask

  task automatic t_random();
    logic [AW-1:0] x;
    for (int i = 0; i < 80; i++) begin
      x = AW'($urandom()) >> ($urandom() % AW);
      if (x == '0) x = AW'(7);
      acc_check(x);
    end
  endtask

  task automatic t_busy_start();
    int lat;
    int extra;
    logic [P-1:0] r;
    @(negedge clk); arg_i = AW'(1000000); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk); lat++;
      if (lat == 3) begin arg_i = AW'(9); start_i = 1'b1; end
      if (lat == 4) start_i = 1'b0;
    end
    r = result_o;
    chk("R6 busy start latency", lat == LAT, lat, LAT);
    chk("R6 busy start result", (r >= 998) && (r <= 1002), r, 1000);
    extra = 0;
    for (int c = 0; c < 2 * LAT; c++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk("R6 no extra done", extra == 0, extra, 0);
    chk("R6 result kept", result_o == r, result_o, r);
  endtask

  task automatic t_hold();
    logic [P-1:0] r;
    int changed;
    run_op(AW'(250000), r);
    changed = 0;
    for (int c = 0; c < 20; c++) begin
      arg_i = AW'($urandom());
      @(negedge clk);
      if (result_o != r || done_o) changed++;
    end
    chk("R7 result hold", changed == 0, changed, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_small();
    t_powers_of_four();
    t_zero();
    t_max();
    t_random();
    t_busy_start();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule